// File: doc/BRIEF.md
# Paged Byte-Memory Serial Slave

This block is a two-wire serial-bus slave that gives a host access to a small on-chip byte memory. The memory is split into eight-byte pages. The slave samples SCL and SDA with the system clock and detects start and stop conditions from those samples. It matches its own seven-bit device address and pulls SDA low through an open-drain enable whenever it has to send a zero.

The host writes through a word-address byte followed by one or more data bytes. It reads either from the current position or from a position it chose with an address-only write. After each read byte, the host's acknowledge decides whether the slave sends another byte. One address counter serves every access. Reads step through the whole array and wrap from the top back to zero. Writes step only within the current page.

An active-high protect input freezes the contents. The slave still acknowledges the bytes so that the host sees normal bus behaviour.

Top module: `pmem_slave`

## Requirements
- R1: The slave acknowledges only a first byte whose upper seven bits equal DEV_ADDR (bit 0 is the direction, 1 = read). Any other first byte gets no ACK, and SDA stays released until the next start condition.
- R2: A byte write is device address with bit 0 = 0, then a word-address byte, then one data byte. Only the low seven bits of the word address are used. The data byte is stored at that address, and the counter moves to the next byte within the page.
- R3: In a page write, each additional data byte goes to the next address. Past page offset 7, the address returns to offset 0 of the same page, and address bits 6..3 never change.
- R4: A read that is not preceded by an address-only write returns the byte at the counter. The counter then advances by one.
- R5: An address-only write followed by a repeated start and a read returns the byte at the written address.
- R6: While the host ACKs each read byte, the slave sends the bytes at successive addresses. After address 127 it continues at address 0.
- R7: After the host NACKs a read byte, the slave drives nothing for the rest of that transaction. Further clocked bits read as 1.
- R8: While wrProtect is high, data bytes are still ACKed but leave the memory unchanged. The counter still advances by the write rule.
- R9: After reset, SDA is released, the counter is 0 and every byte holds 0.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: The slave releases SDA during the host's acknowledge bit after each read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| wrProtect | input | 1 | High blocks every memory update |
| sdaDrvLow | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench builds the block with its default parameters: device address 0x50, 128 bytes and 8-byte pages. With these values, a page write that starts at offset 5 shows the in-page wrap within six bytes. A three-byte sequential read from address 126 reaches the top-of-array wrap. A behavioural model of the memory and the counter predicts every ACK bit and every read byte. A mismatched address and reads after a NACK show that the slave stays off the line.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic shiftRx;     // capture sampled SDA into receive shifter
    logic loadTx;      // load transmit shifter from memory at counter
    logic shiftTx;     // present next transmit bit
    logic driveAck;    // pull SDA low for an ACK bit
    logic releaseSda;  // stop pulling SDA
    logic setAddr;     // load counter from received word address
    logic writeStep;   // store received byte, step counter in page
    logic readStep;    // step counter across the whole array
  } strb_t;

  // Bus events from datapath to control
  typedef struct packed {
    logic       sclRise;
    logic       sclFall;
    logic       startCond;
    logic       stopCond;
    logic       sdaBit;
    logic [7:0] rxByte;
  } bus_ev_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_t;

endpackage

// File: rtl/pmem_dpath.sv
module pmem_dpath
  import pmem_pkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    wrProtect,
  input  strb_t   strb,
  output bus_ev_t ev,
  output logic    sdaDrvLow
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic [7:0] rxReg, txReg;
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0] memArr [MEM_BYTES];
  logic [7:0] curByte;

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign curByte = memArr[addrCnt];

  // Two-flop synchronizers plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    ev.sclRise   = sclS && !sclPrev;
    ev.sclFall   = !sclS && sclPrev;
    ev.startCond = sclS && sclPrev && sdaPrev && !sdaS;
    ev.stopCond  = sclS && sclPrev && !sdaPrev && sdaS;
    ev.sdaBit    = sdaS;
    ev.rxByte    = rxReg;
  end

  // Shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
    end else begin
      if (strb.shiftRx) rxReg <= {rxReg[6:0], sdaS};
      if (strb.loadTx)       txReg <= curByte;
      else if (strb.shiftTx) txReg <= {txReg[6:0], 1'b0};
    end
  end

  // Open-drain output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          sdaDrvLow <= 1'b0;
    else if (ev.startCond || ev.stopCond || strb.releaseSda) sdaDrvLow <= 1'b0;
    else if (strb.driveAck)                             sdaDrvLow <= 1'b1;
    else if (strb.loadTx)                               sdaDrvLow <= ~curByte[7];
    else if (strb.shiftTx)                              sdaDrvLow <= ~txReg[6];
  end

  // Shared address counter: array-wide step for reads, in-page step for writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrCnt <= '0;
    else if (strb.setAddr)   addrCnt <= rxReg[ADDR_W-1:0];
    else if (strb.writeStep) addrCnt <= {addrCnt[ADDR_W-1:PAGE_W],
                                         addrCnt[PAGE_W-1:0] + PAGE_W'(1)};
    else if (strb.readStep)  addrCnt <= addrCnt + ADDR_W'(1);
  end

  // Storage array, cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= '0;
    end else if (strb.writeStep && !wrProtect) begin
      memArr[addrCnt] <= rxReg;
    end
  end

  // R10
  sda_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclPrev && !ev.startCond && !ev.stopCond) |=> $stable(sdaDrvLow));

  // R3
  page_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeStep |=> (addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W])));

  // R8
  protect_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeStep && wrProtect) |=> (memArr[$past(addrCnt)] == $past(curByte)));

  // R6
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readStep && addrCnt == ADDR_W'(MEM_BYTES - 1)) |=> (addrCnt == '0));

endmodule

// File: rtl/pmem_ctrl.sv
module pmem_ctrl
  import pmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic    clk,
  input  logic    rstN,
  input  bus_ev_t ev,
  input  logic    busDrv,
  output strb_t   strb
);
  slv_state_t state, nState;
  logic [3:0] bitCnt, nBit;
  logic       rwBit, nRw;
  logic       mAck, nMAck;

  always_comb begin
    strb   = '0;
    nState = state;
    nBit   = bitCnt;
    nRw    = rwBit;
    nMAck  = mAck;
    if (ev.startCond) begin
      nState          = ST_DEVADDR;
      nBit            = '0;
      strb.releaseSda = 1'b1;
    end else if (ev.stopCond) begin
      nState          = ST_IDLE;
      nBit            = '0;
      strb.releaseSda = 1'b1;
    end else begin
      unique case (state)
        ST_DEVADDR, ST_WADDR, ST_WDATA: begin
          if (ev.sclRise && bitCnt < 4'd8) begin
            strb.shiftRx = 1'b1;
            nBit         = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            nBit = '0;
            if (state == ST_DEVADDR) begin
              if (ev.rxByte[7:1] == DEV_ADDR) begin
                strb.driveAck = 1'b1;
                nRw           = ev.rxByte[0];
                nState        = ST_DEVACK;
              end else begin
                nState = ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              strb.driveAck = 1'b1;
              strb.setAddr  = 1'b1;
              nState        = ST_ACK;
            end else begin
              strb.driveAck  = 1'b1;
              strb.writeStep = 1'b1;
              nState         = ST_ACK;
            end
          end
        end
        ST_DEVACK: begin
          if (ev.sclFall) begin
            if (rwBit) begin
              strb.loadTx   = 1'b1;
              strb.readStep = 1'b1;
              nState        = ST_RDATA;
            end else begin
              strb.releaseSda = 1'b1;
              nState          = ST_WADDR;
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            strb.releaseSda = 1'b1;
            nState          = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (ev.sclRise) begin
            nBit = bitCnt + 4'd1;
          end else if (ev.sclFall) begin
            if (bitCnt == 4'd8) begin
              strb.releaseSda = 1'b1;
              nBit            = '0;
              nMAck           = 1'b0;
              nState          = ST_RACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ev.sclRise) begin
            nMAck = !ev.sdaBit;
          end else if (ev.sclFall) begin
            if (mAck) begin
              strb.loadTx   = 1'b1;
              strb.readStep = 1'b1;
              nState        = ST_RDATA;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rwBit  <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= nState;
      bitCnt <= nBit;
      rwBit  <= nRw;
      mAck   <= nMAck;
    end
  end

  // R11
  host_ack_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK) |-> !busDrv);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !busDrv);

  // R6
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);

endmodule

// File: rtl/pmem_slave.sv
module pmem_slave
  import pmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         MEM_BYTES  = 128,
  parameter int         PAGE_BYTES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wrProtect,
  output logic sdaDrvLow
);
  strb_t   strb;
  bus_ev_t ev;

  pmem_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ev     (ev),
    .busDrv (sdaDrvLow),
    .strb   (strb)
  );

  pmem_dpath #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .wrProtect (wrProtect),
    .strb      (strb),
    .ev        (ev),
    .sdaDrvLow (sdaDrvLow)
  );

endmodule

// File: tb/pmem_slave_test.sv
module pmem_slave_test;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic sdaDrvLow;
  logic sdaLine;
  int   nCmp = 0;
  int   nBad = 0;
  int   cyc = 0;

  // reference model
  byte unsigned refMem [128];
  int           refAddr = 0;

  assign sdaLine = sdaM & ~sdaDrvLow;

  always #4 clk = ~clk;

  pmem_slave #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .wrProtect(wp), .sdaDrvLow(sdaDrvLow)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clkBit(input logic b, output logic seen);
    sclM = 1'b0; tick(5);
    sdaM = b;    tick(5);
    sclM = 1'b1; tick(5);
    seen = sdaLine; tick(5);
  endtask

  task automatic busStart();
    sclM = 1'b0; tick(5);
    sdaM = 1'b1; tick(5);
    sclM = 1'b1; tick(10);
    sdaM = 1'b0; tick(10);
  endtask

  task automatic busStop();
    sclM = 1'b0; tick(5);
    sdaM = 1'b0; tick(5);
    sclM = 1'b1; tick(10);
    sdaM = 1'b1; tick(10);
  endtask

  task automatic sendByte(input byte unsigned b, input bit expAck, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(b[i], s);
    clkBit(1'b1, s);
    check((s == 1'b0) == expAck, tag, int'(!s), int'(expAck));
  endtask

  task automatic recvByte(output byte unsigned b, input bit ackIt);
    logic s;
    b = 0;
    for (int i = 0; i < 8; i++) begin
      clkBit(1'b1, s);
      b = {b[6:0], s};
    end
    sclM = 1'b0; tick(5);
    sdaM = !ackIt; tick(5);
    sclM = 1'b1; tick(5);
    check(sdaDrvLow == 1'b0, "R11 host ack bit released", int'(sdaDrvLow), 0);
    tick(5);
  endtask

  // model-driven transactions
  task automatic doWrite(input int a, input byte unsigned d[$], input string tag);
    busStart();
    sendByte({DEV, 1'b0}, 1'b1, tag);
    sendByte(byte'(a), 1'b1, tag);
    refAddr = a & 8'h7f;
    foreach (d[k]) begin
      sendByte(d[k], 1'b1, tag);
      if (!wp) refMem[refAddr] = d[k];
      refAddr = (refAddr & 8'h78) | ((refAddr + 1) & 8'h07);
    end
    busStop();
  endtask

  task automatic readRun(input int n, input string tag);
    byte unsigned got;
    for (int k = 0; k < n; k++) begin
      recvByte(got, k != n - 1);
      check(got == refMem[refAddr], tag, got, refMem[refAddr]);
      refAddr = (refAddr + 1) & 8'h7f;
    end
  endtask

  task automatic doCurRead(input int n, input string tag);
    busStart();
    sendByte({DEV, 1'b1}, 1'b1, tag);
    readRun(n, tag);
    busStop();
  endtask

  task automatic doRandRead(input int a, input int n, input string tag);
    busStart();
    sendByte({DEV, 1'b0}, 1'b1, tag);
    sendByte(byte'(a), 1'b1, tag);
    refAddr = a & 8'h7f;
    busStart();
    sendByte({DEV, 1'b1}, 1'b1, tag);
    readRun(n, tag);
    busStop();
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    byte unsigned got;
    byte unsigned q[$];
    for (int i = 0; i < 128; i++) refMem[i] = 0;
    tick(10);
    rstN = 1'b1;
    tick(10);

    // R9: reset state
    check(sdaDrvLow == 1'b0, "R9 released after reset", int'(sdaDrvLow), 0);
    // R9 R4: current-address read of fresh memory
    doCurRead(2, "R4 R9 current read from reset");

    // R1: foreign address ignored
    busStart();
    sendByte({7'h23, 1'b0}, 1'b0, "R1 foreign address no ack");
    sendByte(8'h00, 1'b0, "R1 stays off bus");
    busStop();

    // R2: byte write, top bit of word address ignored
    q = '{8'hA5};
    doWrite(8'h90, q, "R2 byte write");
    doCurRead(1, "R4 counter after byte write");
    // R5: random read
    doRandRead(8'h10, 1, "R5 random read");

    // R3: page write wrapping inside page 3
    q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    doWrite(8'h1D, q, "R3 page write");
    doCurRead(1, "R3 counter in page after wrap");
    doRandRead(8'h18, 8, "R3 R6 sequential page readback");

    // R6: top-of-array wrap during sequential read
    q = '{8'h3C};
    doWrite(8'h7F, q, "R6 write top byte");
    q = '{8'h77};
    doWrite(8'h00, q, "R6 write byte zero");
    doRandRead(8'h7E, 3, "R6 sequential wrap 127 to 0");

    // R8: protected write acked, memory unchanged, counter steps
    wp = 1'b1;
    q = '{8'h11, 8'h22};
    doWrite(8'h10, q, "R8 protected write ack");
    wp = 1'b0;
    doCurRead(1, "R8 counter advanced under protect");
    doRandRead(8'h10, 2, "R8 contents unchanged");

    // R7: after NACK the slave stays off the line
    busStart();
    sendByte({DEV, 1'b1}, 1'b1, "R7 read header");
    recvByte(got, 1'b0);
    check(got == refMem[refAddr], "R7 byte before nack", got, refMem[refAddr]);
    refAddr = (refAddr + 1) & 8'h7f;
    recvByte(got, 1'b0);
    check(got == 8'hFF, "R7 released after nack", got, 8'hFF);
    busStop();
    check(sdaDrvLow == 1'b0, "R10 idle after stop", int'(sdaDrvLow), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule